// File: doc/BRIEF.md
# Turn-Restricted Mesh Route Selector

This block is the route-computation stage of a router in a two-dimensional mesh. For each header it receives the router's own coordinates, the destination coordinates, the direction the packet was travelling when it arrived, and one congestion flag for each of the four mesh outputs. From these it forms the set of productive outputs that the selected turn discipline allows. It then picks one output and registers the result one clock later.

Three partially adaptive disciplines are available. Each one bans two of the eight ninety-degree turns, so routing stays free of deadlock while keeping some choice of path. A plain X-then-Y mode is included as a non-adaptive baseline. The block also reports whether the turn from the arrival direction into the chosen output is banned under the active discipline. A correctly routed packet never raises this flag. A raised flag points to upstream misrouting or a change of mode while the packet is in flight.

Top module: `turn_route_unit`

## Requirements
- R1: While `rst` is high at a clock edge, every output is cleared to zero on that edge.
- R2: `out_valid` equals `in_valid` delayed by one clock. A request is captured only when `in_valid` is high, and the other outputs keep their values in cycles where `in_valid` is low.
- R3: Output encoding is bit 0 local, bit 1 +x (east), bit 2 -x (west), bit 3 +y (north), bit 4 -y (south). When the current and destination coordinates are equal, the permitted set and the chosen port are both local (`5'b00001`) in every mode. Coordinates are unsigned, and +x and +y mean a larger coordinate.
- R4: Mode 0 (dimension order) permits only +x or -x while the X coordinates differ, and then only +y or -y. Congestion flags have no effect in this mode.
- R5: Mode 1 (west first) permits only -x whenever the destination lies west. Otherwise it permits every productive direction among +x, +y and -y.
- R6: Mode 2 (north last) never permits +y while an X offset remains. It then permits the productive directions among +x, -x and -y. With no X offset it permits the productive one of +y and -y.
- R7: Mode 3 (negative first) permits only the productive negative directions (-x, -y) while any exist. After that it permits the productive positive directions.
- R8: The chosen port is a single bit inside the permitted set. It is the lowest-numbered permitted port whose congestion flag is clear. `port_busy` bit 0 flags +x, bit 1 flags -x, bit 2 flags +y and bit 3 flags -y.
- R9: When every permitted mesh port is congested, the lowest-numbered permitted port is chosen.
- R10: `out_turn_bad` is set when the turn from `in_prev_dir` into the chosen port is banned. `in_prev_dir` uses 0 for injected and 1 to 4 for +x, -x, +y, -y; values above 4 count as injected. The banned turns are: mode 0, any y travel into x; mode 1, +y or -y into -x; mode 2, +y into +x or -x; mode 3, +x into -y and +y into -x. Going straight, U-turns and ejection are never flagged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request present this cycle |
| in_mode | input | 2 | Turn discipline: 0 XY, 1 west first, 2 north last, 3 negative first |
| cur_x | input | COORD_W | This router's X coordinate |
| cur_y | input | COORD_W | This router's Y coordinate |
| dst_x | input | COORD_W | Destination X coordinate |
| dst_y | input | COORD_W | Destination Y coordinate |
| in_prev_dir | input | 3 | Arrival travel direction (0 injected, 1..4 = +x,-x,+y,-y) |
| port_busy | input | 4 | Congestion flags for +x,-x,+y,-y |
| out_valid | output | 1 | Registered request valid |
| out_port | output | 5 | One-hot chosen output |
| out_permit | output | 5 | Permitted output set |
| out_turn_bad | output | 1 | Chosen turn is banned under the mode |

## Verification
The block has no state beyond its output register, so any internal fault appears on the ports in the cycle right after the request. Faults in the permission logic show up on `out_permit` for some mode and quadrant. Faults in the priority or congestion logic show up as a wrong bit in `out_port` whenever two or more ports are permitted. The comparison runs on every cycle, so a corrupted bit is caught at the first request that reaches the faulty logic. Directed cases cover each quadrant in each mode, plus the fully congested case and the illegal-arrival cases. Random requests cover the remaining mix.

// File: rtl/turn_route_pkg.sv
package turn_route_pkg;

    localparam int NPORT   = 5;
    localparam int NMESH   = NPORT - 1;
    localparam int DIR_W   = 3;

    typedef enum logic [1:0] {
        MODE_XY = 2'd0,
        MODE_WF = 2'd1,
        MODE_NL = 2'd2,
        MODE_NF = 2'd3
    } route_mode_e;

    typedef enum logic [DIR_W-1:0] {
        DIR_LOCAL = 3'd0,
        DIR_XP    = 3'd1,
        DIR_XN    = 3'd2,
        DIR_YP    = 3'd3,
        DIR_YN    = 3'd4
    } dir_e;

    typedef logic [NPORT-1:0] port_mask_t;

    // Productive directions toward the destination
    typedef struct packed {
        logic yn;
        logic yp;
        logic xn;
        logic xp;
    } heading_t;

    typedef struct packed {
        logic       valid;
        port_mask_t port;
        port_mask_t permit;
        logic       turn_bad;
    } route_res_t;

    function automatic port_mask_t dir_bit(dir_e d);
        return port_mask_t'(1) << d;
    endfunction

    // Isolate lowest set bit: lower index is higher priority
    function automatic port_mask_t lowest_set(port_mask_t m);
        return m & (~m + port_mask_t'(1));
    endfunction

    function automatic logic is_y(dir_e d);
        return (d == DIR_YP) || (d == DIR_YN);
    endfunction

    function automatic logic is_x(dir_e d);
        return (d == DIR_XP) || (d == DIR_XN);
    endfunction

    // Two banned 90-degree turns per adaptive discipline; XY bans all y->x
    function automatic logic turn_banned(route_mode_e m, dir_e from, dir_e to);
        logic r;
        unique case (m)
            MODE_XY: r = is_y(from) && is_x(to);
            MODE_WF: r = is_y(from) && (to == DIR_XN);
            MODE_NL: r = (from == DIR_YP) && is_x(to);
            MODE_NF: r = ((from == DIR_XP) && (to == DIR_YN)) ||
                         ((from == DIR_YP) && (to == DIR_XN));
            default: r = 1'b0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/turn_route_permit.sv
module turn_route_permit
    import turn_route_pkg::*;
#(
    parameter int COORD_W = 4
) (
    input  route_mode_e        mode,
    input  logic [COORD_W-1:0] cur_x,
    input  logic [COORD_W-1:0] cur_y,
    input  logic [COORD_W-1:0] dst_x,
    input  logic [COORD_W-1:0] dst_y,
    output port_mask_t         permit
);

    heading_t   hd;
    port_mask_t prod;
    port_mask_t neg_prod;

    always_comb begin
        hd.xp = dst_x > cur_x;
        hd.xn = dst_x < cur_x;
        hd.yp = dst_y > cur_y;
        hd.yn = dst_y < cur_y;
        prod  = {hd.yn, hd.yp, hd.xn, hd.xp, 1'b0};
        neg_prod = prod & (dir_bit(DIR_XN) | dir_bit(DIR_YN));
    end

    always_comb begin
        permit = '0;
        if (prod == '0) begin
            permit = dir_bit(DIR_LOCAL);
        end else begin
            unique case (mode)
                MODE_XY: begin
                    if (hd.xp)      permit = dir_bit(DIR_XP);
                    else if (hd.xn) permit = dir_bit(DIR_XN);
                    else if (hd.yp) permit = dir_bit(DIR_YP);
                    else            permit = dir_bit(DIR_YN);
                end
                MODE_WF: begin
                    if (hd.xn) permit = dir_bit(DIR_XN);
                    else       permit = prod;
                end
                MODE_NL: begin
                    if (hd.xp || hd.xn) permit = prod & ~dir_bit(DIR_YP);
                    else                permit = prod;
                end
                MODE_NF: begin
                    if (neg_prod != '0) permit = neg_prod;
                    else                permit = prod;
                end
                default: permit = prod;
            endcase
        end
    end

endmodule

// File: rtl/turn_route_pick.sv
module turn_route_pick
    import turn_route_pkg::*;
(
    input  port_mask_t        permit,
    input  logic [NMESH-1:0]  busy,
    output port_mask_t        choice
);

    port_mask_t avail;

    always_comb begin
        // local port never reports congestion
        avail  = permit & ~{busy, 1'b0};
        choice = (avail != '0) ? lowest_set(avail) : lowest_set(permit);
    end

endmodule

// File: rtl/turn_route_guard.sv
module turn_route_guard
    import turn_route_pkg::*;
(
    input  route_mode_e       mode,
    input  logic [DIR_W-1:0]  prev_dir,
    input  port_mask_t        choice,
    output logic              banned
);

    dir_e from_d;
    logic [NPORT-1:0] hit;

    always_comb begin
        from_d = (prev_dir < DIR_W'(NPORT)) ? dir_e'(prev_dir) : DIR_LOCAL;
    end

    for (genvar g = 0; g < NPORT; g++) begin : g_turn
        assign hit[g] = choice[g] && turn_banned(mode, from_d, dir_e'(g));
    end

    assign banned = |hit;

endmodule

// File: rtl/turn_route_unit.sv
module turn_route_unit
    import turn_route_pkg::*;
#(
    parameter int COORD_W = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    input  logic [1:0]         in_mode,
    input  logic [COORD_W-1:0] cur_x,
    input  logic [COORD_W-1:0] cur_y,
    input  logic [COORD_W-1:0] dst_x,
    input  logic [COORD_W-1:0] dst_y,
    input  logic [2:0]         in_prev_dir,
    input  logic [3:0]         port_busy,
    output logic               out_valid,
    output logic [4:0]         out_port,
    output logic [4:0]         out_permit,
    output logic               out_turn_bad
);

    route_mode_e mode;
    port_mask_t  permit_c;
    port_mask_t  choice_c;
    logic        banned_c;
    route_res_t  res_q;

    assign mode = route_mode_e'(in_mode);

    turn_route_permit #(.COORD_W(COORD_W)) u_permit (
        .mode   (mode),
        .cur_x  (cur_x),
        .cur_y  (cur_y),
        .dst_x  (dst_x),
        .dst_y  (dst_y),
        .permit (permit_c)
    );

    turn_route_pick u_pick (
        .permit (permit_c),
        .busy   (port_busy),
        .choice (choice_c)
    );

    turn_route_guard u_guard (
        .mode     (mode),
        .prev_dir (in_prev_dir),
        .choice   (choice_c),
        .banned   (banned_c)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q <= '0;
        end else begin
            res_q.valid <= in_valid;
            if (in_valid) begin
                res_q.port     <= choice_c;
                res_q.permit   <= permit_c;
                res_q.turn_bad <= banned_c;
            end
        end
    end

    assign out_valid    = res_q.valid;
    assign out_port     = res_q.port;
    assign out_permit   = res_q.permit;
    assign out_turn_bad = res_q.turn_bad;

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(out_port) && $stable(out_permit)) else $error("hold"); // R2
    AST_ARRIVED_LOCAL: assert property (@(posedge clk) disable iff (rst)
        in_valid && cur_x == dst_x && cur_y == dst_y |=> out_port == 5'b00001) else $error("local"); // R3
    AST_XY_X_FIRST: assert property (@(posedge clk) disable iff (rst)
        in_valid && in_mode == 2'd0 && cur_x != dst_x |=> out_port[2:1] != 2'b00) else $error("xy"); // R4
    AST_WF_WEST_ONLY: assert property (@(posedge clk) disable iff (rst)
        in_valid && in_mode == 2'd1 && dst_x < cur_x |=> out_permit == 5'b00100) else $error("wf"); // R5
    AST_NL_NO_NORTH: assert property (@(posedge clk) disable iff (rst)
        in_valid && in_mode == 2'd2 && cur_x != dst_x |=> !out_permit[3]) else $error("nl"); // R6
    AST_NF_NEG_FIRST: assert property (@(posedge clk) disable iff (rst)
        in_valid && in_mode == 2'd3 && (dst_x < cur_x || dst_y < cur_y)
        |=> !out_port[1] && !out_port[3]) else $error("nf"); // R7
    AST_ONE_HOT_PICK: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $countones(out_port) == 1 && (out_port & ~out_permit) == '0) else $error("onehot"); // R8
    AST_AVOID_BUSY: assert property (@(posedge clk) disable iff (rst)
        in_valid && in_mode != 2'd0 && ((permit_c & ~{port_busy, 1'b0}) != '0)
        |=> (out_port & {$past(port_busy), 1'b0}) == '0) else $error("busy"); // R8

endmodule

// File: tb/turn_route_unit_bench.sv
module turn_route_unit_bench;

    localparam int CW = 4;

    logic          clk = 1'b0;
    logic          rst;
    logic          in_valid;
    logic [1:0]    in_mode;
    logic [CW-1:0] cur_x, cur_y, dst_x, dst_y;
    logic [2:0]    in_prev_dir;
    logic [3:0]    port_busy;
    logic          out_valid;
    logic [4:0]    out_port;
    logic [4:0]    out_permit;
    logic          out_turn_bad;

    int n_tests = 0;
    int n_fail  = 0;

    logic [4:0] exp_port, exp_perm;
    logic       exp_bad;

    always #10 clk = ~clk;

    turn_route_unit #(.COORD_W(CW)) u_turn_route_unit (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_mode(in_mode),
        .cur_x(cur_x), .cur_y(cur_y), .dst_x(dst_x), .dst_y(dst_y),
        .in_prev_dir(in_prev_dir), .port_busy(port_busy),
        .out_valid(out_valid), .out_port(out_port), .out_permit(out_permit),
        .out_turn_bad(out_turn_bad)
    );

    task automatic check(input string tag, input logic [4:0] act, input logic [4:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    // Behavioural reference derived from the requirement text
    function automatic bit banned(int m, int from, int to);
        if (from > 4) from = 0;
        case (m)
            0: return (from == 3 || from == 4) && (to == 1 || to == 2);
            1: return (from == 3 || from == 4) && to == 2;
            2: return from == 3 && (to == 1 || to == 2);
            default: return (from == 1 && to == 4) || (from == 3 && to == 2);
        endcase
    endfunction

    task automatic model(input int m, input int cx, input int cy, input int tx, input int ty,
                         input logic [3:0] cg, input int prev);
        bit e, w, n, s;
        int first, free, sel;
        e = tx > cx; w = tx < cx; n = ty > cy; s = ty < cy;
        exp_perm = '0;
        if (!e && !w && !n && !s) exp_perm = 5'b00001;
        else if (m == 0) begin
            if (e) exp_perm[1] = 1; else if (w) exp_perm[2] = 1;
            else if (n) exp_perm[3] = 1; else exp_perm[4] = 1;
        end else if (m == 1) begin
            if (w) exp_perm[2] = 1;
            else begin exp_perm[1] = e; exp_perm[3] = n; exp_perm[4] = s; end
        end else if (m == 2) begin
            if (e || w) begin exp_perm[1] = e; exp_perm[2] = w; exp_perm[4] = s; end
            else begin exp_perm[3] = n; exp_perm[4] = s; end
        end else begin
            if (w || s) begin exp_perm[2] = w; exp_perm[4] = s; end
            else begin exp_perm[1] = e; exp_perm[3] = n; end
        end
        first = -1; free = -1;
        for (int i = 0; i < 5; i++) begin
            if (exp_perm[i]) begin
                if (first < 0) first = i;
                if (free < 0 && (i == 0 || !cg[i-1])) free = i;
            end
        end
        sel = (free >= 0) ? free : first;
        exp_port = 5'b00001 << sel;
        exp_bad  = banned(m, prev, sel);
    endtask

    function automatic string mode_tag(int m);
        case (m)
            0: return "R4";
            1: return "R5";
            2: return "R6";
            default: return "R7";
        endcase
    endfunction

    // Drive at negedge, result registered at next posedge, sampled at following negedge
    task automatic req(input int m, input int cx, input int cy, input int tx, input int ty,
                       input logic [3:0] cg, input int prev);
        string ptag;
        in_valid = 1'b1; in_mode = 2'(m);
        cur_x = CW'(cx); cur_y = CW'(cy); dst_x = CW'(tx); dst_y = CW'(ty);
        port_busy = cg; in_prev_dir = 3'(prev);
        model(m, cx, cy, tx, ty, cg, prev);
        @(posedge clk); @(negedge clk);
        if (exp_perm == 5'b00001)                       ptag = "R3";
        else if ((exp_perm & ~{cg, 1'b0}) == 5'b0)      ptag = "R9";
        else if ($countones(exp_perm) > 1)              ptag = "R8";
        else                                            ptag = mode_tag(m);
        check("R2 out_valid", {4'b0, out_valid}, 5'b00001);
        check(ptag, out_port, exp_port);
        check(mode_tag(m), out_permit, exp_perm);
        check("R10", {4'b0, out_turn_bad}, {4'b0, exp_bad});
    endtask

    task automatic idle_hold();
        in_valid = 1'b0;
        cur_x = ~cur_x; dst_y = dst_y + 4'd3; port_busy = ~port_busy; in_mode = in_mode + 2'd1;
        @(posedge clk); @(negedge clk);
        check("R2 valid low", {4'b0, out_valid}, 5'b0);
        check("R2 port held", out_port, exp_port);
        check("R2 permit held", out_permit, exp_perm);
    endtask

    initial begin
        #(20 * 200000);
        n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        rst = 1'b1; in_valid = 1'b1; in_mode = 2'd1;
        cur_x = 4'd3; cur_y = 4'd3; dst_x = 4'd9; dst_y = 4'd1;
        in_prev_dir = 3'd0; port_busy = 4'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset clears everything even with a request present
        check("R1 valid", {4'b0, out_valid}, 5'b0);
        check("R1 port", out_port, 5'b0);
        check("R1 permit", out_permit, 5'b0);
        check("R1 bad", {4'b0, out_turn_bad}, 5'b0);
        rst = 1'b0;

        // R3 arrived, every mode, all congested
        for (int m = 0; m < 4; m++) req(m, 5, 5, 5, 5, 4'b1111, 3);
        // R4 dimension order ignores congestion
        req(0, 2, 2, 6, 1, 4'b0001, 0);
        req(0, 4, 2, 4, 7, 4'b0100, 3);
        req(0, 9, 9, 1, 12, 4'b0010, 2);
        // R5 west first
        req(1, 6, 3, 2, 5, 4'b0010, 0);
        req(1, 2, 3, 6, 6, 4'b0001, 0);
        req(1, 2, 8, 6, 3, 4'b0001, 1);
        // R6 north last
        req(2, 2, 2, 5, 6, 4'b0001, 0);
        req(2, 5, 2, 5, 6, 4'b0000, 3);
        req(2, 5, 6, 2, 1, 4'b0010, 2);
        // R7 negative first
        req(3, 2, 6, 6, 2, 4'b0000, 0);
        req(3, 6, 6, 2, 2, 4'b0010, 0);
        req(3, 2, 2, 6, 6, 4'b0001, 0);
        // R9 all permitted ports busy
        req(3, 2, 2, 6, 6, 4'b1111, 0);
        req(1, 2, 9, 7, 3, 4'b1101, 0);
        // R10 banned turns on arrival, plus legal straight and U-turn
        req(1, 6, 3, 2, 3, 4'b0000, 3);
        req(2, 2, 3, 6, 3, 4'b0000, 3);
        req(3, 6, 6, 6, 2, 4'b0000, 1);
        req(0, 3, 3, 8, 3, 4'b0000, 4);
        req(0, 3, 3, 8, 3, 4'b0000, 1);
        req(1, 3, 3, 8, 3, 4'b0000, 2);
        req(3, 6, 3, 2, 3, 4'b0000, 7);
        // R2 inputs ignored while idle
        idle_hold();
        req(2, 1, 1, 4, 0, 4'b0000, 0);
        idle_hold();

        for (int k = 0; k < 600; k++) begin
            req($urandom_range(0, 3), $urandom_range(0, 15), $urandom_range(0, 15),
                $urandom_range(0, 15), $urandom_range(0, 15),
                4'($urandom_range(0, 15)), $urandom_range(0, 7));
            if (k % 50 == 7) idle_hold();
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule